// File: doc/BRIEF.md
# Effective-Address Generation Unit

This unit turns one decoded operand specifier into a usable operand location. Each request carries an addressing-mode code, a transfer size, the number of the base register, a literal field (an immediate value or an absolute address), and a signed offset field. The caller supplies the two register-file read values and the program counter. One cycle later the unit presents either an immediate operand, a register selection, or a byte effective address. For the two auto-stepping modes it also presents a write-back request that updates the base register.

The unit has no register file and no memory port of its own. When a mode needs a pointer fetched from memory, it places the pointer location on a request output and raises a busy flag. The surrounding pipeline performs the read and returns the fetched word. That word becomes the effective address one cycle later. While busy, new requests are dropped. The caller must hold them until busy falls.

Top module: `ea_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `wb_en`, `busy` and `ind_req` are all low.
- R2: Mode code 0 (immediate) gives, one cycle after an accepted request, `out_valid`=1, `out_kind`=1 and `out_data` equal to the literal field.
- R3: Mode code 1 (register) gives `out_kind`=2, `out_reg` equal to the requested register number and `out_data` equal to the first register read value.
- R4: Mode code 2 (absolute) gives `out_kind`=0 and `out_data` equal to the literal field.
- R5: Mode code 3 (register indirect) gives `out_kind`=0 and `out_data` equal to the first register read value.
- R6: Mode code 5 (indexed) gives first register value plus offset. Mode code 6 (based indexed) gives first register plus second register plus offset. The offset field is sign-extended from its top bit, and the sum wraps modulo 2^DW.
- R7: Mode code 7 (relative) gives the program counter plus the sign-extended offset.
- R8: Mode code 8 (post-increment) gives the unmodified register value as the address. It also writes back register value plus step, where step is 1 for `req_size`=0 (byte) and DW/8 for `req_size`=1 (word).
- R9: Mode code 9 (pre-decrement) gives register value minus step as the address. It writes the same value back to the register.
- R10: `wb_en` is high only in the result cycle of modes 8 and 9. `wb_idx` then names the requested register.
- R11: Mode code 4 (memory indirect) raises `busy` and `ind_req` in the cycle after acceptance, with `ind_addr` equal to the literal field. These hold until a cycle with `ind_valid` high. In the following cycle, `busy` is low and the result is `out_kind`=0 with `out_data` equal to the returned word.
- R12: Requests presented while `busy` is high produce no output and no write-back.
- R13: Mode codes 10 to 15 produce no output and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Addressing-mode code |
| req_size | input | 1 | 0 byte, 1 word access |
| req_ri | input | RIW | Base register number |
| req_value | input | DW | Literal field (immediate or absolute location) |
| req_offset | input | XW | Signed offset field |
| ri_val | input | DW | Read value of base register |
| rj_val | input | DW | Read value of index register |
| pc_val | input | DW | Program counter |
| ind_valid | input | 1 | Fetched pointer word is present |
| ind_data | input | DW | Fetched pointer word |
| out_valid | output | 1 | Result present |
| out_kind | output | 2 | 0 address, 1 immediate, 2 register |
| out_data | output | DW | Address, immediate or register value |
| out_reg | output | RIW | Selected register number |
| wb_en | output | 1 | Base register write-back request |
| wb_idx | output | RIW | Register to write back |
| wb_data | output | DW | Updated base value |
| ind_req | output | 1 | Pointer fetch request |
| ind_addr | output | DW | Pointer location |
| busy | output | 1 | Waiting for pointer word |

## Verification
Some rules are checked by assertions on every cycle:
- no result appears while busy;
- the pointer location stays stable during a fetch;
- a returned word always ends the busy period with a result;
- any write-back is an address-kind result whose written value equals the address, or the address plus a legal step.

Other behaviour only shows up in the bench's scenarios, compared cycle by cycle against a behavioural model:
- the arithmetic of each mode, including negative offsets and wrap-around;
- the byte-versus-word step;
- the handling of unassigned codes;
- dropping requests during a fetch.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM  = 4'd0,
    AM_REG  = 4'd1,
    AM_ABS  = 4'd2,
    AM_RIND = 4'd3,
    AM_MIND = 4'd4,
    AM_IDX  = 4'd5,
    AM_BIX  = 4'd6,
    AM_REL  = 4'd7,
    AM_AINC = 4'd8,
    AM_ADEC = 4'd9
  } am_t;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_IMM  = 2'd1,
    KIND_REG  = 2'd2
  } kind_t;
endpackage

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int DW  = 32,
  parameter int XW  = 16,
  parameter int RIW = 5
) (
  input  logic [ea_pkg::MODE_W-1:0] mode,
  input  logic                      size,
  input  logic [DW-1:0]             value,
  input  logic [XW-1:0]             offset,
  input  logic [DW-1:0]             ri_val,
  input  logic [DW-1:0]             rj_val,
  input  logic [DW-1:0]             pc_val,
  output logic                      known,
  output logic                      is_ind,
  output ea_pkg::kind_t             kind,
  output logic [DW-1:0]             data,
  output logic                      wb_en,
  output logic [DW-1:0]             wb_data
);
  import ea_pkg::*;

  localparam int WORD_BYTES = DW / 8;

  logic [DW-1:0] off_ext;
  logic [DW-1:0] step;
  logic [DW-1:0] base_plus_off;

  generate
    if (XW >= DW) begin : g_trunc
      assign off_ext = offset[DW-1:0];
    end else begin : g_sext
      assign off_ext = {{(DW-XW){offset[XW-1]}}, offset};
    end
  endgenerate

  assign step          = size ? DW'(WORD_BYTES) : DW'(1);
  assign base_plus_off = ri_val + off_ext;

  always_comb begin
    known   = 1'b1;
    is_ind  = 1'b0;
    kind    = KIND_ADDR;
    data    = '0;
    wb_en   = 1'b0;
    wb_data = '0;
    case (mode)
      AM_IMM:  begin kind = KIND_IMM; data = value; end
      AM_REG:  begin kind = KIND_REG; data = ri_val; end
      AM_ABS:  data = value;
      AM_RIND: data = ri_val;
      AM_MIND: begin is_ind = 1'b1; data = value; end
      AM_IDX:  data = base_plus_off;
      AM_BIX:  data = base_plus_off + rj_val;
      AM_REL:  data = pc_val + off_ext;
      AM_AINC: begin
        data    = ri_val;
        wb_en   = 1'b1;
        wb_data = ri_val + step;
      end
      AM_ADEC: begin
        data    = ri_val - step;
        wb_en   = 1'b1;
        wb_data = ri_val - step;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_ind_ctrl.sv
module ea_ind_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] loc,
  input  logic          ind_valid,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] ind_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ind_addr <= '0;
    end else if (busy) begin
      if (ind_valid) busy <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      ind_addr <= loc;
    end
  end

  assign done = busy & ind_valid;

  AST_IND_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ind_addr)); // R11
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int DW  = 32,
  parameter int XW  = 16,
  parameter int RIW = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ea_pkg::MODE_W-1:0] req_mode,
  input  logic                      req_size,
  input  logic [RIW-1:0]            req_ri,
  input  logic [DW-1:0]             req_value,
  input  logic [XW-1:0]             req_offset,
  input  logic [DW-1:0]             ri_val,
  input  logic [DW-1:0]             rj_val,
  input  logic [DW-1:0]             pc_val,
  input  logic                      ind_valid,
  input  logic [DW-1:0]             ind_data,
  output logic                      out_valid,
  output logic [1:0]                out_kind,
  output logic [DW-1:0]             out_data,
  output logic [RIW-1:0]            out_reg,
  output logic                      wb_en,
  output logic [RIW-1:0]            wb_idx,
  output logic [DW-1:0]             wb_data,
  output logic                      ind_req,
  output logic [DW-1:0]             ind_addr,
  output logic                      busy
);
  import ea_pkg::*;

  localparam int WORD_BYTES = DW / 8;

  logic          c_known, c_ind, c_wb;
  kind_t         c_kind;
  logic [DW-1:0] c_data, c_wb_data;
  logic          accept, ind_start, ind_done;

  ea_calc #(.DW(DW), .XW(XW), .RIW(RIW)) u_calc (
    .mode(req_mode), .size(req_size), .value(req_value), .offset(req_offset),
    .ri_val(ri_val), .rj_val(rj_val), .pc_val(pc_val),
    .known(c_known), .is_ind(c_ind), .kind(c_kind), .data(c_data),
    .wb_en(c_wb), .wb_data(c_wb_data)
  );

  assign accept    = req_valid & ~busy & c_known;
  assign ind_start = accept & c_ind;

  ea_ind_ctrl #(.DW(DW)) u_ind (
    .clk(clk), .rst(rst), .start(ind_start), .loc(c_data),
    .ind_valid(ind_valid), .busy(busy), .done(ind_done), .ind_addr(ind_addr)
  );

  assign ind_req = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= KIND_ADDR;
      out_data  <= '0;
      out_reg   <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      if (ind_done) begin
        out_valid <= 1'b1;
        out_kind  <= KIND_ADDR;
        out_data  <= ind_data;
      end else if (accept && !c_ind) begin
        out_valid <= 1'b1;
        out_kind  <= c_kind;
        out_data  <= c_data;
        out_reg   <= req_ri;
        wb_en     <= c_wb;
        wb_idx    <= req_ri;
        wb_data   <= c_wb_data;
      end
    end
  end

  AST_NO_OUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !out_valid); // R12
  AST_IND_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    $past(busy && ind_valid) |-> (out_valid && !busy && out_kind == KIND_ADDR)); // R11
  AST_WB_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (out_valid && out_kind == KIND_ADDR && wb_idx == out_reg)); // R10
  AST_WB_STEP: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data == out_data || wb_data == out_data + DW'(1) ||
               wb_data == out_data + DW'(WORD_BYTES))); // R8
endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
  localparam int DW = 32, XW = 16, RIW = 5;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_size = 0, ind_valid = 0;
  logic [3:0] req_mode = 0;
  logic [RIW-1:0] req_ri = 0;
  logic [DW-1:0] req_value = 0, ri_val = 0, rj_val = 0, pc_val = 0, ind_data = 0;
  logic [XW-1:0] req_offset = 0;
  logic out_valid, wb_en, ind_req, busy;
  logic [1:0] out_kind;
  logic [DW-1:0] out_data, wb_data, ind_addr;
  logic [RIW-1:0] out_reg, wb_idx;

  ea_unit #(.DW(DW), .XW(XW), .RIW(RIW)) u_dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  // reference model state
  logic m_valid = 0, m_wb = 0, m_busy = 0;
  logic [1:0] m_kind = 0;
  logic [DW-1:0] m_data = 0, m_wbd = 0, m_loc = 0;
  logic [RIW-1:0] m_reg = 0;
  string m_tag = "R1";

  function automatic logic [DW-1:0] sx(input logic [XW-1:0] x);
    return {{(DW-XW){x[XW-1]}}, x};
  endfunction

  always @(posedge clk) begin
    logic [DW-1:0] st;
    st = req_size ? 32'd4 : 32'd1;
    if (rst) begin
      m_valid = 0; m_wb = 0; m_busy = 0; m_tag = "R1";
    end else begin
      m_valid = 0; m_wb = 0; m_tag = "R1";
      if (m_busy) begin
        m_tag = req_valid ? "R12" : "R11";
        if (ind_valid) begin
          m_busy = 0; m_valid = 1; m_kind = 0; m_data = ind_data; m_tag = "R11";
        end
      end else if (req_valid) begin
        m_valid = 1; m_kind = 0; m_reg = req_ri;
        case (req_mode)
          0: begin m_kind = 1; m_data = req_value; m_tag = "R2"; end
          1: begin m_kind = 2; m_data = ri_val; m_tag = "R3"; end
          2: begin m_data = req_value; m_tag = "R4"; end
          3: begin m_data = ri_val; m_tag = "R5"; end
          4: begin m_valid = 0; m_busy = 1; m_loc = req_value; m_tag = "R11"; end
          5: begin m_data = ri_val + sx(req_offset); m_tag = "R6"; end
          6: begin m_data = ri_val + rj_val + sx(req_offset); m_tag = "R6"; end
          7: begin m_data = pc_val + sx(req_offset); m_tag = "R7"; end
          8: begin m_data = ri_val; m_wb = 1; m_wbd = ri_val + st; m_tag = "R8"; end
          9: begin m_data = ri_val - st; m_wb = 1; m_wbd = ri_val - st; m_tag = "R9"; end
          default: begin m_valid = 0; m_tag = "R13"; end
        endcase
      end
    end
  end

  task automatic chk(input string what, input string tag, input logic [DW-1:0] a, input logic [DW-1:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, a, e);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("out_valid", m_tag, 32'(out_valid), 32'(m_valid));
      chk("busy", (m_tag == "R12") ? "R12" : "R11", 32'(busy), 32'(m_busy));
      chk("ind_req", "R11", 32'(ind_req), 32'(m_busy));
      chk("wb_en", m_wb ? m_tag : "R10", 32'(wb_en), 32'(m_wb));
      if (m_busy) chk("ind_addr", "R11", ind_addr, m_loc);
      if (m_valid) begin
        chk("out_kind", m_tag, 32'(out_kind), 32'(m_kind));
        chk("out_data", m_tag, out_data, m_data);
        if (m_kind == 2) chk("out_reg", m_tag, 32'(out_reg), 32'(m_reg));
      end
      if (m_wb) begin
        chk("wb_idx", "R10", 32'(wb_idx), 32'(m_reg));
        chk("wb_data", m_tag, wb_data, m_wbd);
      end
    end
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input logic [3:0] md, input logic sz, input logic [RIW-1:0] ri,
                       input logic [DW-1:0] v, input logic [XW-1:0] off,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] pc);
    @(negedge clk);
    req_valid = 1; req_mode = md; req_size = sz; req_ri = ri; req_value = v;
    req_offset = off; ri_val = a; rj_val = b; pc_val = pc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; ind_valid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("reset out_valid", "R1", 32'(out_valid), 0);
    chk("reset wb_en", "R1", 32'(wb_en), 0);
    chk("reset busy", "R1", 32'(busy), 0);
    chk("reset ind_req", "R1", 32'(ind_req), 0);
    issue(0, 0, 3, 32'hDEAD_BEEF, 0, 1, 2, 3);          // R2
    issue(1, 0, 7, 0, 0, 32'h1234, 0, 0);               // R3
    issue(2, 1, 1, 32'h0000_4000, 16'h8000, 5, 6, 7);   // R4
    issue(3, 0, 2, 0, 0, 32'h0000_0200, 0, 0);          // R5
    issue(5, 0, 4, 0, 16'hFFFC, 32'h100, 0, 0);         // R6 negative offset
    issue(5, 0, 4, 0, 16'h7FFF, 32'hFFFF_FFF0, 0, 0);   // R6 wrap
    issue(6, 0, 4, 0, 16'h0010, 32'h100, 32'h20, 0);    // R6 base+index
    issue(7, 0, 0, 0, 16'hFF00, 0, 0, 32'h0000_0080);   // R7 negative
    issue(8, 0, 9, 0, 0, 32'h50, 0, 0);                 // R8 byte
    issue(8, 1, 9, 0, 0, 32'hFFFF_FFFE, 0, 0);          // R8 word wrap
    issue(9, 0, 10, 0, 0, 32'h50, 0, 0);                // R9 byte
    issue(9, 1, 10, 0, 0, 32'h2, 0, 0);                 // R9 word wrap
    issue(12, 0, 1, 0, 0, 32'h9, 0, 0);                 // R13
    issue(15, 1, 1, 0, 0, 32'h9, 0, 0);                 // R13
    idle(1);
    // R11 memory indirect with a dropped request (R12)
    issue(4, 0, 0, 32'h0000_0300, 0, 0, 0, 0);
    idle(2);
    issue(8, 0, 5, 0, 0, 32'h77, 0, 0);                 // R12 ignored
    idle(1);
    @(negedge clk); ind_valid = 1; ind_data = 32'hCAFE_0000;
    idle(2);
    // back-to-back indirect then normal
    issue(4, 1, 0, 32'h0000_0400, 0, 0, 0, 0);
    @(negedge clk); req_valid = 0; ind_valid = 1; ind_data = 32'h0000_1000;
    issue(7, 0, 0, 0, 16'h0004, 0, 0, 32'h10);
    idle(2);
    for (int k = 0; k < 300; k++) begin
      logic [3:0] md;
      md = 4'($urandom_range(0, 15));
      issue(md, 1'($urandom), 5'($urandom), $urandom, 16'($urandom), $urandom, $urandom, $urandom);
      if (md == 4) begin
        idle(1 + $urandom_range(0, 3));
        @(negedge clk); ind_valid = 1; ind_data = $urandom;
        idle(1);
      end
    end
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule